// File: doc/BRIEF.md
# I/O Expander Register Bank with Change Interrupts

This block is the register bank behind a general-purpose pin expander with a fan-speed output. A serial bus slave, which is not part of this block, turns bus transactions into single-cycle read and write strobes with a byte address. The bank stores the settings for configuration, pin direction, output drive, interrupt mask, pin data and fan speed. It also keeps a read-only interrupt status register.

Pins set as inputs are synchronized, and each level change on them is recorded in the status register. Recording cannot be masked. The active-low alert line is pulled low only when two things hold: the global enable is on, and an unmasked change has arrived. The alert is released either by an acknowledge pulse from the external slave, which leaves status intact, or by a read of the status register, which also clears status.

Top module: `xpdr_regfile`

## Requirements
- R1: Addresses 00h configuration, 01h direction, 02h output configuration, 04h mask, 05h data and 06h fan speed are 8-bit read/write, and a read returns the value last written. A read of any address above 06h returns 00h, and a write there has no effect.
- R2: After reset, every register reads 00h except data (05h), which reads FFh, and alert_n is high.
- R3: The status register (03h) is read-only. A write to it leaves its contents unchanged.
- R4: A level change on a pin whose direction bit is 1 (input) sets the matching status bit whatever the mask holds. A change on a pin whose direction bit is 0 (output) sets nothing.
- R5: A status read returns the pending bits and clears them all. Several changes on one pin between reads show as one set bit.
- R6: alert_n goes low only if configuration bit 0 (global enable) is 1 and a change arrives on a pin whose mask bit is 1. A change on a pin with mask bit 0 never pulls it low.
- R7: A one-cycle ara_ack releases alert_n and leaves the status bits unchanged.
- R8: A status read releases alert_n.
- R9: A change that arrives in the same cycle as a clearing status read stays set in status.
- R10: After an acknowledge, a new unmasked change pulls alert_n low again.
- R11: A data read returns the synchronized pin level for input bits and the stored value for output bits.
- R12: rdata is valid on the clock edge after the cycle in which rd_en is sampled. A pin change shows in status and alert_n on the third edge after the pin moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| addr | input | ADDR_W | Register byte address |
| wdata | input | PIN_W | Write data |
| rdata | output | PIN_W | Registered read data |
| pins_in | input | PIN_W | Pin levels from the pads |
| ara_ack | input | 1 | Alert-response acknowledge pulse |
| alert_n | output | 1 | Active-low alert, registered |
| dir_o | output | PIN_W | Direction register, 1 = input |
| outcfg_o | output | PIN_W | Output configuration register |
| data_o | output | PIN_W | Stored data register |
| fan_o | output | PIN_W | Fan speed register |

## Verification
Read data is due one edge after the read strobe is sampled. A pin change reaches status and alert_n on the third edge after the pin moves: two synchronizer stages, then the status flop. The driver queues each expected read value when it raises the strobe. The monitor pops that value at the falling edge after the following rising edge. Alert and status checks after pin moves wait exactly three rising edges and sample at the next falling edge. The same-cycle read-and-change case is timed so that the read strobe is sampled on that third edge.

// File: rtl/xpdr_pkg.sv
package xpdr_pkg;
  localparam int REG_CFG  = 0;
  localparam int REG_DIR  = 1;
  localparam int REG_OCFG = 2;
  localparam int REG_STAT = 3;
  localparam int REG_MASK = 4;
  localparam int REG_DATA = 5;
  localparam int REG_FAN  = 6;
  localparam int IE_BIT   = 0;
endpackage

// File: rtl/xpdr_insync.sv
module xpdr_insync #(
  parameter int PIN_W  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIN_W-1:0] pins_i,
  input  logic [PIN_W-1:0] dir_i,
  output logic [PIN_W-1:0] sync_o,
  output logic [PIN_W-1:0] chg_o
);
  logic [PIN_W-1:0] stg [STAGES];
  logic [PIN_W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= pins_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= stg[STAGES-1];
  end

  assign sync_o = stg[STAGES-1];
  assign chg_o  = (stg[STAGES-1] ^ prev_q) & dir_i;
endmodule

// File: rtl/xpdr_irq.sv
module xpdr_irq #(
  parameter int PIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIN_W-1:0] chg_i,
  input  logic             clr_rd_i,
  input  logic             ack_i,
  input  logic             ie_nx_i,
  input  logic [PIN_W-1:0] mask_nx_i,
  output logic [PIN_W-1:0] status_o,
  output logic             alert_n_o
);
  logic [PIN_W-1:0] status_q, status_nx;
  logic             arm_q, arm_nx, hit;

  always_comb begin
    status_nx = (clr_rd_i ? '0 : status_q) | chg_i;
    hit       = |(chg_i & mask_nx_i);
    arm_nx    = ((clr_rd_i || ack_i) ? 1'b0 : arm_q) | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q  <= '0;
      arm_q     <= 1'b0;
      alert_n_o <= 1'b1;
    end else begin
      status_q  <= status_nx;
      arm_q     <= arm_nx;
      alert_n_o <= ~(arm_nx & ie_nx_i & (|(status_nx & mask_nx_i)));
    end
  end

  assign status_o = status_q;

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    clr_rd_i |=> status_q == $past(chg_i)); // R5
  AST_ACK_KEEPS_STATUS: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !clr_rd_i) |=> status_q == ($past(status_q) | $past(chg_i))); // R7
  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (rst)
    ((ack_i || clr_rd_i) && !(|(chg_i & mask_nx_i))) |=> alert_n_o); // R8
  AST_REARM: assert property (@(posedge clk) disable iff (rst)
    (ie_nx_i && (|(chg_i & mask_nx_i))) |=> !alert_n_o); // R10
endmodule

// File: rtl/xpdr_regfile.sv
module xpdr_regfile #(
  parameter int PIN_W  = 8,
  parameter int ADDR_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PIN_W-1:0]  wdata,
  output logic [PIN_W-1:0]  rdata,
  input  logic [PIN_W-1:0]  pins_in,
  input  logic              ara_ack,
  output logic              alert_n,
  output logic [PIN_W-1:0]  dir_o,
  output logic [PIN_W-1:0]  outcfg_o,
  output logic [PIN_W-1:0]  data_o,
  output logic [PIN_W-1:0]  fan_o
);
  import xpdr_pkg::*;

  logic [PIN_W-1:0] cfg_q, dir_q, ocfg_q, mask_q, data_q, fan_q;
  logic [PIN_W-1:0] sync_w, chg_w, status_w, mask_nx, rd_mux;
  logic             ie_nx, clr_rd;

  function automatic logic hit_a(input logic [ADDR_W-1:0] a, input int r);
    return a == ADDR_W'(r);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      dir_q  <= '0;
      ocfg_q <= '0;
      mask_q <= '0;
      data_q <= '1;
      fan_q  <= '0;
    end else if (wr_en) begin
      if (hit_a(addr, REG_CFG))  cfg_q  <= wdata;
      if (hit_a(addr, REG_DIR))  dir_q  <= wdata;
      if (hit_a(addr, REG_OCFG)) ocfg_q <= wdata;
      if (hit_a(addr, REG_MASK)) mask_q <= wdata;
      if (hit_a(addr, REG_DATA)) data_q <= wdata;
      if (hit_a(addr, REG_FAN))  fan_q  <= wdata;
    end
  end

  always_comb begin
    ie_nx   = (wr_en && hit_a(addr, REG_CFG))  ? wdata[IE_BIT] : cfg_q[IE_BIT];
    mask_nx = (wr_en && hit_a(addr, REG_MASK)) ? wdata : mask_q;
    clr_rd  = rd_en && hit_a(addr, REG_STAT);
    rd_mux  = '0;
    if      (hit_a(addr, REG_CFG))  rd_mux = cfg_q;
    else if (hit_a(addr, REG_DIR))  rd_mux = dir_q;
    else if (hit_a(addr, REG_OCFG)) rd_mux = ocfg_q;
    else if (hit_a(addr, REG_STAT)) rd_mux = status_w;
    else if (hit_a(addr, REG_MASK)) rd_mux = mask_q;
    else if (hit_a(addr, REG_DATA)) rd_mux = (data_q & ~dir_q) | (sync_w & dir_q);
    else if (hit_a(addr, REG_FAN))  rd_mux = fan_q;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  xpdr_insync #(.PIN_W(PIN_W), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .pins_i(pins_in), .dir_i(dir_q),
    .sync_o(sync_w), .chg_o(chg_w)
  );

  xpdr_irq #(.PIN_W(PIN_W)) u_irq (
    .clk(clk), .rst(rst), .chg_i(chg_w), .clr_rd_i(clr_rd), .ack_i(ara_ack),
    .ie_nx_i(ie_nx), .mask_nx_i(mask_nx), .status_o(status_w), .alert_n_o(alert_n)
  );

  assign dir_o    = dir_q;
  assign outcfg_o = ocfg_q;
  assign data_o   = data_q;
  assign fan_o    = fan_q;

  AST_ALERT_GATED: assert property (@(posedge clk) disable iff (rst)
    !alert_n |-> (cfg_q[IE_BIT] && (|(status_w & mask_q)))); // R6
  AST_RESET_VALUES: assert property (@(posedge clk)
    rst |=> (data_q == '1 && fan_q == '0 && cfg_q == '0 && alert_n && status_w == '0)); // R2
  AST_STAT_READONLY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_a(addr, REG_STAT) && !clr_rd) |=> status_w == ($past(status_w) | $past(chg_w))); // R3
  AST_CHG_INPUT_ONLY: assert property (@(posedge clk) disable iff (rst)
    (chg_w & ~dir_q) == '0); // R4
endmodule

// File: tb/sim_xpdr_regfile.sv
module sim_xpdr_regfile;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, ara_ack = 1'b0;
  logic [7:0] addr = '0, wdata = '0, pins_in = '0;
  logic [7:0] rdata, dir_o, outcfg_o, data_o, fan_o;
  logic       alert_n;
  logic       rd_d = 1'b0;
  int         n_run = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  xpdr_regfile u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pins_in(pins_in), .ara_ack(ara_ack),
    .alert_n(alert_n), .dir_o(dir_o), .outcfg_o(outcfg_o), .data_o(data_o), .fan_o(fan_o)
  );

  always @(posedge clk) rd_d <= rd_en;

  // monitor: pops the expected read value once rdata is due
  always @(negedge clk) begin
    if (rd_d && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s rdata actual %02h expected %02h", t, rdata, e);
      end
    end
  end

  task automatic chk(input string t, input logic [7:0] act, input logic [7:0] e);
    n_run++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s actual %02h expected %02h", t, act, e);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    addr = a; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pins(input logic [7:0] v);
    pins_in = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL R12 watchdog actual hang expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R2 alert_n reset", {7'b0, alert_n}, 8'h01);
    rd(8'h00, 8'h00, "R2 cfg");
    rd(8'h01, 8'h00, "R2 dir");
    rd(8'h02, 8'h00, "R2 ocfg");
    rd(8'h03, 8'h00, "R2 status");
    rd(8'h04, 8'h00, "R2 mask");
    rd(8'h05, 8'hFF, "R2 data");
    rd(8'h06, 8'h00, "R2 fan");
    // R1 read/write
    wr(8'h01, 8'hF0); wr(8'h02, 8'h5A); wr(8'h04, 8'h30);
    wr(8'h06, 8'h99); wr(8'h05, 8'h0C); wr(8'h07, 8'h77);
    rd(8'h01, 8'hF0, "R1 dir");
    rd(8'h02, 8'h5A, "R1 ocfg");
    rd(8'h04, 8'h30, "R1 mask");
    rd(8'h06, 8'h99, "R1 fan");
    rd(8'h07, 8'h00, "R1 unmapped");
    chk("R1 fan_o", fan_o, 8'h99);
    chk("R1 outcfg_o", outcfg_o, 8'h5A);
    chk("R11 data mixed", data_o, 8'h0C);
    rd(8'h05, 8'h0C, "R11 data read");
    // R3 status read-only
    wr(8'h03, 8'hFF);
    rd(8'h03, 8'h00, "R3 status write ignored");
    // R4 output pin change ignored, input pin masked still latches
    pins(8'h01);
    rd(8'h03, 8'h00, "R4 output pin");
    pins(8'h81);
    chk("R6 masked no alert", {7'b0, alert_n}, 8'h01);
    rd(8'h03, 8'h80, "R4 input pin");
    rd(8'h03, 8'h00, "R5 cleared");
    // R6 enable off
    pins(8'h91);
    chk("R6 ie off", {7'b0, alert_n}, 8'h01);
    rd(8'h03, 8'h10, "R4 status bit4");
    wr(8'h00, 8'h01);
    rd(8'h00, 8'h01, "R1 cfg");
    pins(8'h11);
    chk("R6 masked with ie", {7'b0, alert_n}, 8'h01);
    pins(8'h01);
    chk("R6 alert low", {7'b0, alert_n}, 8'h00);
    // R7 ack
    ara_ack = 1'b1; @(posedge clk); @(negedge clk); ara_ack = 1'b0;
    chk("R7 ack releases", {7'b0, alert_n}, 8'h01);
    rd(8'h03, 8'h90, "R7 status kept");
    // R10 re-arm, R8 read release
    pins(8'h11);
    chk("R10 rearm", {7'b0, alert_n}, 8'h00);
    rd(8'h03, 8'h10, "R8 status");
    chk("R8 read releases", {7'b0, alert_n}, 8'h01);
    // R5 merge
    pins(8'h01); pins(8'h11); pins(8'h01);
    rd(8'h03, 8'h10, "R5 merged");
    chk("R8 merged release", {7'b0, alert_n}, 8'h01);
    // R9 change coincident with read
    pins_in = 8'h21;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    rd(8'h03, 8'h00, "R9 read at change");
    chk("R9 alert set", {7'b0, alert_n}, 8'h00);
    rd(8'h03, 8'h20, "R9 change kept");
    // R11 input bits follow pins
    rd(8'h05, 8'h2C, "R11 data inputs");
    repeat (2) @(posedge clk);
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule